// File: doc/BRIEF.md
# Commit Thread Selector

In a simultaneous-multithreading core, the retirement stage must decide each time it is about to retire an instruction which hardware thread supplies that instruction. This block makes that decision. For every thread it receives a status code, a flag that says the thread's reorder-buffer partition is empty, a flag that says the head entry is ready to retire, and the sequence number of that head entry. A static policy input selects one of three arbitration schemes. The block answers a query with a thread index and a valid bit.

Under the age-based schemes (aggressive and oldest-ready), the block picks the eligible thread whose head instruction is oldest, meaning it has the smallest sequence number. Under the rotating scheme, it keeps an ordered list of thread indices. It scans that list from the front and moves the winning thread to the back. The retirement loop may issue one query per clock. Each query's answer appears on registered outputs one cycle later. The rotating list is the block's only state. Reorder-buffer storage is not part of the block.

Top module: `commit_thread_sel`

## Requirements
- R1: After reset, `pick_vld` is 0 and `pick_tid` is 0, and the rotating list holds threads 0, 1, ..., N-1, with thread 0 at the front.
- R2: A query made with `req`=1 is answered on `pick_vld`/`pick_tid` at the next rising clock edge. A cycle with `req`=0 gives `pick_vld`=0 at the following edge.
- R3: Under the age policies, the chosen thread is the eligible thread with the smallest `head_seq` value. Thread t's sequence number is `head_seq[t*SEQ_W +: SEQ_W]`.
- R4: Under the age policies, a thread is eligible only when its `rob_empty` bit is 0, its `head_rdy` bit is 1, and its status is IDLE (0), RUN (1) or FETCH_TRAP (4). Status SQUASH (2) and TRAP (3) exclude the thread. Thread t's status is `thr_status[t*3 +: 3]`.
- R5: When two eligible threads have the same sequence number, the lower thread index wins.
- R6: `policy` codes: 0 = aggressive, 1 = rotating, 2 = oldest-ready. Code 3 behaves like code 2. Aggressive gives the same choice as oldest-ready.
- R7: Under the rotating policy, a thread is eligible only when its status is IDLE or RUN and its `head_rdy` bit is 1. FETCH_TRAP excludes the thread under this policy.
- R8: Under the rotating policy, the chosen thread is the first eligible one in list order, and a successful pick moves it to the back of the list.
- R9: When no thread is eligible, `pick_vld` is 0 and the rotating list is unchanged.
- R10: Queries under the age policies never change the rotating list.
- R11: With NUM_THREADS = 1, the single thread is chosen under every policy whenever its status is IDLE, RUN or FETCH_TRAP, regardless of its empty and ready flags. Otherwise `pick_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Query strobe for this cycle |
| policy | input | 2 | Arbitration scheme select |
| thr_status | input | 3*NUM_THREADS | Per-thread status codes |
| rob_empty | input | NUM_THREADS | Per-thread reorder-buffer empty flag |
| head_rdy | input | NUM_THREADS | Per-thread head-ready flag |
| head_seq | input | SEQ_W*NUM_THREADS | Per-thread head sequence number |
| pick_vld | output | 1 | A thread was chosen for the last query |
| pick_tid | output | max(1,clog2(NUM_THREADS)) | Chosen thread index |

## Verification
A table of age-policy patterns moves the smallest sequence number between threads. It then knocks the oldest thread out in turn by status, by its empty flag and by its ready flag, which tells a true minimum search apart from one that skips the eligibility terms. A tie pattern and a pattern with every thread squashing cover index priority and the no-pick case. Directed rotating sequences follow the list through several picks. These sequences include picks where the front thread is ineligible, an empty query and interleaved age queries, so a wrong move-to-back, a list change on a failed pick or a list change under another policy each produce a different thread index. A second instance with one thread checks the status-only rule.

// File: rtl/cts_pkg.sv
package cts_pkg;

  typedef enum logic [2:0] {
    TS_IDLE   = 3'd0,
    TS_RUN    = 3'd1,
    TS_SQUASH = 3'd2,
    TS_TRAP   = 3'd3,
    TS_FTRAP  = 3'd4
  } thr_state_e;

  typedef enum logic [1:0] {
    POL_AGGR   = 2'd0,
    POL_RR     = 2'd1,
    POL_OLDEST = 2'd2,
    POL_RSVD   = 2'd3
  } policy_e;

  localparam int ST_W = 3;

  function automatic logic st_rr_ok(input logic [ST_W-1:0] s);
    return (s == TS_IDLE) || (s == TS_RUN);
  endfunction

  function automatic logic st_age_ok(input logic [ST_W-1:0] s);
    return (s == TS_IDLE) || (s == TS_RUN) || (s == TS_FTRAP);
  endfunction

endpackage

// File: rtl/cts_elig.sv
module cts_elig
  import cts_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N*ST_W-1:0] thr_status,
  input  logic [N-1:0]      rob_empty,
  input  logic [N-1:0]      head_rdy,
  output logic [N-1:0]      rr_ok,
  output logic [N-1:0]      age_ok
);

  generate
    if (N == 1) begin : g_single
      // one thread: status alone decides, under every policy
      assign rr_ok[0]  = st_age_ok(thr_status[ST_W-1:0]);
      assign age_ok[0] = st_age_ok(thr_status[ST_W-1:0]);
    end else begin : g_multi
      for (genvar t = 0; t < N; t++) begin : g_thr
        logic [ST_W-1:0] st;
        assign st        = thr_status[t*ST_W +: ST_W];
        assign rr_ok[t]  = st_rr_ok(st) && head_rdy[t];
        assign age_ok[t] = st_age_ok(st) && head_rdy[t] && !rob_empty[t];
      end
    end
  endgenerate

endmodule

// File: rtl/cts_age_pick.sv
module cts_age_pick #(
  parameter int N     = 4,
  parameter int SEQ_W = 16,
  localparam int TID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       cand,
  input  logic [N*SEQ_W-1:0] head_seq,
  output logic               hit,
  output logic [TID_W-1:0]   tid
);

  logic [SEQ_W-1:0] best;

  always_comb begin
    hit  = 1'b0;
    tid  = '0;
    best = '0;
    for (int t = 0; t < N; t++) begin
      // strict compare keeps the lower index on equal sequence numbers
      if (cand[t] && (!hit || (head_seq[t*SEQ_W +: SEQ_W] < best))) begin
        hit  = 1'b1;
        tid  = TID_W'(t);
        best = head_seq[t*SEQ_W +: SEQ_W];
      end
    end
  end

endmodule

// File: rtl/cts_rr_order.sv
module cts_rr_order #(
  parameter int N = 4,
  localparam int TID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     cand,
  input  logic             advance,
  output logic             hit,
  output logic [TID_W-1:0] tid
);

  logic [TID_W-1:0] order_q [N];
  logic [TID_W-1:0] order_d [N];
  int               pos;

  always_comb begin
    hit = 1'b0;
    pos = 0;
    for (int p = 0; p < N; p++) begin
      if (!hit && cand[order_q[p]]) begin
        hit = 1'b1;
        pos = p;
      end
    end
    tid = order_q[pos];
  end

  // winner leaves its slot, later entries close the gap, winner goes last
  always_comb begin
    for (int p = 0; p < N; p++) begin
      if (p < pos)
        order_d[p] = order_q[p];
      else if (p < N-1)
        order_d[p] = order_q[(p+1) % N];
      else
        order_d[p] = order_q[pos];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < N; p++) order_q[p] <= TID_W'(p);
    end else if (advance && hit) begin
      for (int p = 0; p < N; p++) order_q[p] <= order_d[p];
    end
  end

endmodule

// File: rtl/commit_thread_sel.sv
module commit_thread_sel
  import cts_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req,
  input  logic [1:0]                   policy,
  input  logic [NUM_THREADS*3-1:0]     thr_status,
  input  logic [NUM_THREADS-1:0]       rob_empty,
  input  logic [NUM_THREADS-1:0]       head_rdy,
  input  logic [NUM_THREADS*SEQ_W-1:0] head_seq,
  output logic                         pick_vld,
  output logic [TID_W-1:0]             pick_tid
);

  logic [NUM_THREADS-1:0] rr_ok, age_ok;
  logic                   age_hit, rr_hit, is_rr, sel_hit;
  logic [TID_W-1:0]       age_tid, rr_tid, sel_tid;

  assign is_rr = (policy == POL_RR);

  cts_elig #(.N(NUM_THREADS)) u_elig (
    .thr_status (thr_status),
    .rob_empty  (rob_empty),
    .head_rdy   (head_rdy),
    .rr_ok      (rr_ok),
    .age_ok     (age_ok)
  );

  cts_age_pick #(.N(NUM_THREADS), .SEQ_W(SEQ_W)) u_age (
    .cand     (age_ok),
    .head_seq (head_seq),
    .hit      (age_hit),
    .tid      (age_tid)
  );

  cts_rr_order #(.N(NUM_THREADS)) u_rr (
    .clk     (clk),
    .rst     (rst),
    .cand    (rr_ok),
    .advance (req && is_rr),
    .hit     (rr_hit),
    .tid     (rr_tid)
  );

  assign sel_hit = is_rr ? rr_hit : age_hit;
  assign sel_tid = is_rr ? rr_tid : age_tid;

  always_ff @(posedge clk) begin
    if (rst) begin
      pick_vld <= 1'b0;
      pick_tid <= '0;
    end else begin
      pick_vld <= req && sel_hit;
      if (req && sel_hit) pick_tid <= sel_tid;
    end
  end

endmodule

// File: rtl/cts_check.sv
module cts_check
  import cts_pkg::*;
#(
  parameter int N     = 4,
  parameter int SEQ_W = 16,
  localparam int TID_W = (N > 1) ? $clog2(N) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             req,
  input logic [1:0]       policy,
  input logic [N*3-1:0]   thr_status,
  input logic [N-1:0]     rob_empty,
  input logic [N-1:0]     head_rdy,
  input logic [N*SEQ_W-1:0] head_seq,
  input logic             pick_vld,
  input logic [TID_W-1:0] pick_tid
);

  logic               q_req;
  logic [1:0]         q_pol;
  logic [N*3-1:0]     q_st;
  logic [N-1:0]       q_emp, q_rdy;
  logic [N*SEQ_W-1:0] q_seq;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_req <= 1'b0; q_pol <= '0; q_st <= '0;
      q_emp <= '0;   q_rdy <= '0; q_seq <= '0;
    end else begin
      q_req <= req;  q_pol <= policy; q_st <= thr_status;
      q_emp <= rob_empty; q_rdy <= head_rdy; q_seq <= head_seq;
    end
  end

  logic [N-1:0] ok_rr, ok_age;
  logic         any_ok, chosen_ok, older_seen, q_is_rr;

  always_comb begin
    q_is_rr = (q_pol == POL_RR);
    for (int t = 0; t < N; t++) begin
      if (N == 1) begin
        ok_rr[t]  = st_age_ok(q_st[t*3 +: 3]);
        ok_age[t] = ok_rr[t];
      end else begin
        ok_rr[t]  = st_rr_ok(q_st[t*3 +: 3]) && q_rdy[t];
        ok_age[t] = st_age_ok(q_st[t*3 +: 3]) && q_rdy[t] && !q_emp[t];
      end
    end
    any_ok     = q_is_rr ? (|ok_rr) : (|ok_age);
    chosen_ok  = q_is_rr ? ok_rr[pick_tid] : ok_age[pick_tid];
    older_seen = 1'b0;
    for (int t = 0; t < N; t++)
      if (ok_age[t] && (q_seq[t*SEQ_W +: SEQ_W] < q_seq[pick_tid*SEQ_W +: SEQ_W]))
        older_seen = 1'b1;
  end

  p_quiet_no_pick_r2: assert property (@(posedge clk) disable iff (rst)
    !req |=> !pick_vld);

  p_pick_eligible_r4: assert property (@(posedge clk) disable iff (rst)
    (pick_vld && !q_is_rr) |-> chosen_ok);

  p_pick_eligible_r7: assert property (@(posedge clk) disable iff (rst)
    (pick_vld && q_is_rr) |-> chosen_ok);

  p_oldest_chosen_r3: assert property (@(posedge clk) disable iff (rst)
    (pick_vld && !q_is_rr) |-> !older_seen);

  p_none_eligible_r9: assert property (@(posedge clk) disable iff (rst)
    (q_req && !any_ok) |-> !pick_vld);

  p_answer_on_hit_r2: assert property (@(posedge clk) disable iff (rst)
    (q_req && any_ok) |-> pick_vld);

endmodule

bind commit_thread_sel cts_check #(.N(NUM_THREADS), .SEQ_W(SEQ_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req        (req),
  .policy     (policy),
  .thr_status (thr_status),
  .rob_empty  (rob_empty),
  .head_rdy   (head_rdy),
  .head_seq   (head_seq),
  .pick_vld   (pick_vld),
  .pick_tid   (pick_tid)
);

// File: tb/sim_commit_thread_sel.sv
`timescale 1ns/1ps
module sim_commit_thread_sel;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [1:0]  policy = 2'd2;
  logic [11:0] st = '0;
  logic [3:0]  emp = '0, rdy = '0;
  logic [63:0] seq = '0;
  logic        vld;
  logic [1:0]  tid;

  logic        s_req = 1'b0;
  logic [1:0]  s_pol = 2'd0;
  logic [2:0]  s_st = '0;
  logic        s_emp = 1'b0, s_rdy = 1'b0;
  logic [15:0] s_seq = '0;
  logic        s_vld;
  logic        s_tid;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  commit_thread_sel #(.NUM_THREADS(4), .SEQ_W(16)) u0 (
    .clk(clk), .rst(rst), .req(req), .policy(policy), .thr_status(st),
    .rob_empty(emp), .head_rdy(rdy), .head_seq(seq),
    .pick_vld(vld), .pick_tid(tid));

  commit_thread_sel #(.NUM_THREADS(1), .SEQ_W(16)) u1 (
    .clk(clk), .rst(rst), .req(s_req), .policy(s_pol), .thr_status(s_st),
    .rob_empty(s_emp), .head_rdy(s_rdy), .head_seq(s_seq),
    .pick_vld(s_vld), .pick_tid(s_tid));

  typedef struct packed {
    logic [1:0]  pol;
    logic [11:0] st;
    logic [3:0]  emp;
    logic [3:0]  rdy;
    logic [63:0] seq;
    logic        ev;
    logic [1:0]  et;
  } vec_t;

  // status fields {t3,t2,t1,t0}: 0 idle, 1 run, 2 squash, 3 trap, 4 fetch-trap
  localparam vec_t VECS [11] = '{
    '{2'd2, {3'd1,3'd1,3'd1,3'd1}, 4'b0000, 4'b1111, {16'd20,16'd30,16'd10,16'd40}, 1'b1, 2'd1},
    '{2'd2, {3'd1,3'd1,3'd2,3'd1}, 4'b0000, 4'b1111, {16'd20,16'd30,16'd10,16'd40}, 1'b1, 2'd3},
    '{2'd2, {3'd3,3'd1,3'd2,3'd1}, 4'b0000, 4'b1111, {16'd20,16'd30,16'd10,16'd40}, 1'b1, 2'd2},
    '{2'd2, {3'd1,3'd4,3'd1,3'd1}, 4'b0000, 4'b1111, {16'd20,16'd5,16'd10,16'd40},  1'b1, 2'd2},
    '{2'd2, {3'd1,3'd1,3'd1,3'd1}, 4'b0100, 4'b1111, {16'd20,16'd5,16'd10,16'd40},  1'b1, 2'd1},
    '{2'd2, {3'd1,3'd1,3'd1,3'd1}, 4'b0000, 4'b1001, {16'd20,16'd5,16'd10,16'd40},  1'b1, 2'd3},
    '{2'd2, {3'd1,3'd1,3'd1,3'd1}, 4'b0000, 4'b1111, {16'd7,16'd9,16'd7,16'd9},     1'b1, 2'd1},
    '{2'd0, {3'd1,3'd1,3'd1,3'd1}, 4'b0000, 4'b1111, {16'd20,16'd30,16'd10,16'd40}, 1'b1, 2'd1},
    '{2'd2, {3'd2,3'd2,3'd2,3'd2}, 4'b0000, 4'b1111, {16'd20,16'd30,16'd10,16'd40}, 1'b0, 2'd0},
    '{2'd0, {3'd0,3'd0,3'd0,3'd0}, 4'b0000, 4'b1111, {16'd0,16'd1,16'd2,16'd3},     1'b1, 2'd3},
    '{2'd3, {3'd1,3'd1,3'd1,3'd1}, 4'b0000, 4'b1111, {16'd20,16'd30,16'd10,16'd40}, 1'b1, 2'd1}
  };

  localparam string VTAG [11] = '{"R3", "R4", "R4", "R4", "R4", "R4", "R5", "R6", "R9", "R6", "R6"};

  localparam logic [11:0] ALL_RUN = {3'd1,3'd1,3'd1,3'd1};
  localparam logic [11:0] ALL_SQ  = {3'd2,3'd2,3'd2,3'd2};

  task automatic check(input string tag, input logic ev, input logic [1:0] et);
    checks++;
    if (vld !== ev || (ev && tid !== et)) begin
      fails++;
      $display("FAIL %s: got vld=%0b tid=%0d, expected vld=%0b tid=%0d", tag, vld, tid, ev, et);
    end
  endtask

  task automatic check1(input string tag, input logic ev);
    checks++;
    if (s_vld !== ev || (ev && s_tid !== 1'b0)) begin
      fails++;
      $display("FAIL %s: got vld=%0b tid=%0d, expected vld=%0b tid=0", tag, s_vld, s_tid, ev);
    end
  endtask

  // drive at a falling edge, answer is registered at the next rising edge
  task automatic ask(input logic [1:0] p, input logic [11:0] s, input logic [3:0] e,
                     input logic [3:0] r, input logic [63:0] q);
    policy = p; st = s; emp = e; rdy = r; seq = q; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic rr(input logic [3:0] r, input logic [11:0] s);
    ask(2'd1, s, 4'b0000, r, 64'd0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;  // R1 reset outputs
    if (vld !== 1'b0 || tid !== 2'd0) begin
      fails++;
      $display("FAIL R1: got vld=%0b tid=%0d, expected vld=0 tid=0", vld, tid);
    end

    for (int i = 0; i < 11; i++) begin
      ask(VECS[i].pol, VECS[i].st, VECS[i].emp, VECS[i].rdy, VECS[i].seq);
      check(VTAG[i], VECS[i].ev, VECS[i].et);
    end

    // R2: a cycle without req yields no pick even with eligible threads
    policy = 2'd2; st = ALL_RUN; rdy = 4'hF; emp = 4'h0; req = 1'b0;
    @(negedge clk);
    check("R2", 1'b0, 2'd0);

    // R8: rotating list from reset order 0,1,2,3
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    rr(4'hF, ALL_RUN); check("R1_R8", 1'b1, 2'd0);      // order 1,2,3,0
    rr(4'hF, ALL_RUN); check("R8", 1'b1, 2'd1);         // order 2,3,0,1
    rr(4'b1011, ALL_RUN); check("R8", 1'b1, 2'd3);      // t2 not ready; order 2,0,1,3
    rr(4'hF, {3'd1,3'd4,3'd1,3'd1}); check("R7", 1'b1, 2'd0); // t2 fetch-trap; order 2,1,3,0
    rr(4'hF, ALL_RUN); check("R8", 1'b1, 2'd2);         // order 1,3,0,2
    rr(4'hF, ALL_SQ);  check("R9", 1'b0, 2'd0);         // no change
    rr(4'hF, ALL_RUN); check("R9", 1'b1, 2'd1);         // order 3,0,2,1
    ask(2'd2, ALL_RUN, 4'h0, 4'hF, {16'd20,16'd30,16'd10,16'd40});
    check("R10", 1'b1, 2'd1);
    ask(2'd0, ALL_RUN, 4'h0, 4'hF, {16'd1,16'd30,16'd10,16'd40});
    check("R10", 1'b1, 2'd3);
    rr(4'hF, ALL_RUN); check("R10", 1'b1, 2'd3);        // list untouched by age queries
    rr(4'hF, {3'd0,3'd0,3'd0,3'd0}); check("R8", 1'b1, 2'd0); // idle threads eligible

    // R11: single-thread instance, status alone decides
    s_pol = 2'd2; s_st = 3'd1; s_emp = 1'b1; s_rdy = 1'b0; s_req = 1'b1;
    @(negedge clk); s_req = 1'b0;
    check1("R11", 1'b1);
    s_st = 3'd2; s_req = 1'b1;
    @(negedge clk); s_req = 1'b0;
    check1("R11", 1'b0);
    s_pol = 2'd1; s_st = 3'd4; s_req = 1'b1;
    @(negedge clk); s_req = 1'b0;
    check1("R11", 1'b1);
    s_pol = 2'd0; s_st = 3'd3; s_req = 1'b1;
    @(negedge clk); s_req = 1'b0;
    check1("R11", 1'b0);

    @(negedge clk);
    summary();
  end

endmodule